// File: doc/BRIEF.md
# Edge-Triggered Auto-Reload Timer

This block is an up-counting timer whose width is a whole number of bytes (two bytes by default). It sits on a small byte-wide register bus. Its counting clock comes from a selectable tick source divided by a two-bit prescaler. When the counter passes its all-ones value it loads itself from a reload register and raises a sticky overflow flag. That flag, combined with an enable bit, drives an interrupt line.

Two start behaviours are offered. In free mode, setting the run bit starts counting at once. In gated mode, setting the run bit only arms the timer. Counting begins after a chosen edge appears on an external trigger pin, which passes through a two-flop synchroniser first. In gated mode the source select is overridden, so the timer always counts system-clock cycles. Clearing the run bit stops the counter and re-arms the edge wait.

Top module: `edge_reload_timer`

## Requirements
- R1: After reset, every readable register returns 0 and `irq` is low.
- R2: Free mode (control bit1 = 0) starts counting as soon as run (control bit0) is 1. Each prescaler output pulse increments the counter by one. The first pulse arrives D active source ticks after run is written.
- R3: The prescale field (control bits 5:4) divides by 1, 8, 64 and 256 for codes 00, 01, 10 and 11.
- R4: An increment from the all-ones value loads the reload value instead, and counting continues from that value.
- R5: The overflow flag is set on rollover. It reads back as status (address 1) bit0. It is cleared at the clock edge on which a read strobe addresses the status register. If a rollover and that strobe occur at the same edge, the flag stays set.
- R6: `irq` equals the overflow flag ANDed with the interrupt enable (control bit7).
- R7: In gated mode (control bit1 = 1), run arms the timer, and status bit1 reads 1 while armed. The counter holds until a selected trigger edge is seen. A pin change just before clock edge E1 allows the first increment at edge E4.
- R8: The trigger edge field (control bits 3:2) selects the edge: 00 rising, 01 falling, 10 either, 11 none.
- R9: In gated mode the source select bit (control bit6) is ignored, and the timer counts system-clock cycles even while `ext_tick` is low.
- R10: In free mode with source select 1, only cycles with `ext_tick` high advance the prescaler.
- R11: Clearing run stops counting, holds the counter and clears the armed and triggered state. Setting run again in gated mode waits for a fresh edge.
- R12: Count bytes (addresses 2, 3, low byte first) and reload bytes (addresses 4, 5) are writable and read back. A count write takes priority over a same-edge increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears overflow when addressing status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| trig_in | input | 1 | External start trigger, asynchronous |
| ext_tick | input | 1 | Alternate count enable for free mode |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler or trigger state appears at the ports as a counter value that is off by one or more at a fixed sample cycle. For the slowest divider this shows within about 512 cycles. A synchroniser of the wrong depth moves the first increment earlier or later by whole cycles, so the bench samples exactly at edge E3 and again a few edges later. A lost reload or a missed overflow shows one edge after rollover, in the count bytes, the status register and `irq` together.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int BYTE_W = 8;

   // trigger edge selection
   localparam logic [1:0] EDGE_RISE = 2'b00;
   localparam logic [1:0] EDGE_FALL = 2'b01;
   localparam logic [1:0] EDGE_ANY  = 2'b10;
   localparam logic [1:0] EDGE_NONE = 2'b11;

   typedef struct packed {
      logic       ien;
      logic       src;
      logic [1:0] psc;
      logic [1:0] edge_sel;
      logic       gated;
      logic       run;
   } ctrl_t;

   localparam int ADDR_CTRL = 0;
   localparam int ADDR_STAT = 1;
   localparam int ADDR_CNT0 = 2;
endpackage

// File: rtl/tmr_trig_detect.sv
module tmr_trig_detect #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trig_in,
   input  logic [1:0] edge_sel,
   output logic       hit
);
   import tmr_pkg::*;

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_trig_detect: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= trig_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];

   logic rise, fall;
   assign rise = sync_q[STAGES-1] & ~last_q;
   assign fall = ~sync_q[STAGES-1] & last_q;

   always_comb begin
      unique case (edge_sel)
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         EDGE_ANY:  hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int DIV1 = 8,
   parameter int DIV2 = 64,
   parameter int DIV3 = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       src_tick,
   input  logic [1:0] code,
   output logic       pulse
);
   localparam int CW = $clog2(DIV3);

   if (DIV1 < 2 || DIV2 <= DIV1 || DIV3 <= DIV2) begin : g_bad_div
      $error("tmr_prescaler: dividers must rise strictly from at least 2");
   end

   logic [CW-1:0] pcnt_q;
   logic [CW-1:0] limit;

   always_comb begin
      unique case (code)
         2'd0: limit = '0;
         2'd1: limit = CW'(DIV1 - 1);
         2'd2: limit = CW'(DIV2 - 1);
         default: limit = CW'(DIV3 - 1);
      endcase
   end

   assign pulse = active & src_tick & (pcnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pcnt_q <= '0;
      else if (!active)       pcnt_q <= '0;
      else if (src_tick) begin
         if (pcnt_q >= limit) pcnt_q <= '0;
         else                 pcnt_q <= pcnt_q + 1'b1;
      end
   end

   // R3: with a divider above one, two pulses never fall on consecutive edges
   p_pulse_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && code != 2'd0 && $stable(code)) |=> !pulse);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int BYTES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [BYTES-1:0]     wr_en,
   input  logic [7:0]           wdata,
   input  logic [BYTES*8-1:0]   reload,
   output logic [BYTES*8-1:0]   count,
   output logic                 wrap
);
   localparam int W = BYTES * 8;
   localparam logic [W-1:0] MAXV = '1;

   if (BYTES < 1) begin : g_bad_bytes
      $error("tmr_counter: BYTES must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic         any_wr;

   assign any_wr = |wr_en;
   assign wrap   = tick & ~any_wr & (cnt_q == MAXV);
   assign count  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (any_wr) begin
         for (int i = 0; i < BYTES; i++)
            if (wr_en[i]) cnt_q[i*8 +: 8] <= wdata;
      end
      else if (tick) begin
         if (cnt_q == MAXV) cnt_q <= reload;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4: a rollover lands on the reload value
   p_reload_on_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt_q == $past(reload));
   // R2: a tick without a write and without rollover adds exactly one
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !any_wr && cnt_q != MAXV) |=> cnt_q == $past(cnt_q) + W'(1));
   // R11: no tick and no write leaves the count unchanged
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !any_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/edge_reload_timer.sv
module edge_reload_timer #(
   parameter int CNT_BYTES   = 2,
   parameter int SYNC_STAGES = 2,
   parameter int DIV1        = 8,
   parameter int DIV2        = 64,
   parameter int DIV3        = 256,
   parameter bit TRIG_EN     = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [$clog2(2+2*CNT_BYTES)-1:0]     reg_addr,
   input  logic                                 reg_wr,
   input  logic                                 reg_rd,
   input  logic [7:0]                           reg_wdata,
   output logic [7:0]                           reg_rdata,
   input  logic                                 trig_in,
   input  logic                                 ext_tick,
   output logic                                 irq
);
   import tmr_pkg::*;

   localparam int W        = CNT_BYTES * BYTE_W;
   localparam int ADDR_W   = $clog2(2 + 2*CNT_BYTES);
   localparam int RLD_BASE = ADDR_CNT0 + CNT_BYTES;

   if (CNT_BYTES < 1 || CNT_BYTES > 4) begin : g_bad_width
      $error("edge_reload_timer: CNT_BYTES must be 1..4");
   end

   ctrl_t          ctrl_q;
   logic           ovf_q;
   logic           trig_q;
   logic [W-1:0]   reload_q;
   logic [W-1:0]   count;
   logic           wrap;
   logic           hit;
   logic           pulse;
   logic [CNT_BYTES-1:0] cnt_wr;

   // ---------------- decode ----------------
   logic wr_ctrl, rd_stat;
   assign wr_ctrl = reg_wr && reg_addr == ADDR_W'(ADDR_CTRL);
   assign rd_stat = reg_rd && reg_addr == ADDR_W'(ADDR_STAT);

   always_comb begin
      for (int i = 0; i < CNT_BYTES; i++)
         cnt_wr[i] = reg_wr && reg_addr == ADDR_W'(ADDR_CNT0 + i);
   end

   // ---------------- run state ----------------
   logic armed, active, eff_src, src_tick;
   assign armed    = ctrl_q.run & ctrl_q.gated & ~trig_q;
   assign active   = ctrl_q.run & (~ctrl_q.gated | trig_q);
   assign eff_src  = ctrl_q.gated ? 1'b0 : ctrl_q.src;
   assign src_tick = eff_src ? ext_tick : 1'b1;

   // ---------------- trigger variant ----------------
   if (TRIG_EN) begin : g_trig
      tmr_trig_detect #(.STAGES(SYNC_STAGES)) u_trig (
         .clk      (clk),
         .rst_n    (rst_n),
         .trig_in  (trig_in),
         .edge_sel (ctrl_q.edge_sel),
         .hit      (hit)
      );
   end else begin : g_no_trig
      assign hit = 1'b0;
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata);
         for (int i = 0; i < CNT_BYTES; i++)
            if (reg_wr && reg_addr == ADDR_W'(RLD_BASE + i))
               reload_q[i*8 +: 8] <= reg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            trig_q <= 1'b0;
      else if (!ctrl_q.run || !ctrl_q.gated) trig_q <= 1'b0;
      else if (hit)                          trig_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (wrap)    ovf_q <= 1'b1;
      else if (rd_stat) ovf_q <= 1'b0;
   end

   // ---------------- datapath ----------------
   tmr_prescaler #(.DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .src_tick (src_tick),
      .code     (ctrl_q.psc),
      .pulse    (pulse)
   );

   tmr_counter #(.BYTES(CNT_BYTES)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (pulse),
      .wr_en  (cnt_wr),
      .wdata  (reg_wdata),
      .reload (reload_q),
      .count  (count),
      .wrap   (wrap)
   );

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADDR_CTRL)) reg_rdata = ctrl_q;
      if (reg_addr == ADDR_W'(ADDR_STAT)) reg_rdata = {6'b0, armed, ovf_q};
      for (int i = 0; i < CNT_BYTES; i++) begin
         if (reg_addr == ADDR_W'(ADDR_CNT0 + i)) reg_rdata = count[i*8 +: 8];
         if (reg_addr == ADDR_W'(RLD_BASE + i))  reg_rdata = reload_q[i*8 +: 8];
      end
   end

   assign irq = ovf_q & ctrl_q.ien;

   // R7: while armed the counter does not move unless software writes it
   p_armed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cnt_wr == '0) |=> $stable(count));
   // R4: a rollover always leaves the flag set
   p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_q);
   // R5: the flag only drops through a status read strobe
   p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !rd_stat) |=> ovf_q);
   // R6: no request without the enable bit
   p_irq_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctrl_q.ien);
endmodule

// File: tb/edge_reload_timer_test.sv
module edge_reload_timer_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] reg_addr;
   logic       reg_wr, reg_rd;
   logic [7:0] reg_wdata, reg_rdata;
   logic       trig_in, ext_tick, irq;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   edge_reload_timer uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .trig_in(trig_in), .ext_tick(ext_tick), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      reg_addr = a;
      #1 v = int'(reg_rdata);
   endtask

   task automatic get_cnt(output int v);
      int lo, hi;
      rd(3'd2, lo);
      rd(3'd3, hi);
      v = (hi << 8) | lo;
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_stat();
      reg_addr = 3'd1; reg_rd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic gated_case(input int e, input logic start, input bit fires,
                             input string tag, input bit rerun);
      int v, s, held;
      wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      trig_in = start; ext_tick = 1'b0;
      wait_edges(4);
      // gated, run, source select set (must be ignored, R9)
      wr(3'd0, 8'h43 | 8'(e << 2));
      wait_edges(5);
      get_cnt(v); chk({"R7 armed hold ", tag}, v, 0);
      rd(3'd1, s); chk({"R7 armed status ", tag}, s, 2);
      trig_in = ~start;
      wait_edges(3);
      get_cnt(v); chk({"R7 no count before E4 ", tag}, v, 0);
      wait_edges(5);
      get_cnt(v); chk({"R8 R9 count after edge ", tag}, v, fires ? 5 : 0);
      rd(3'd1, s); chk({"R8 status after edge ", tag}, s, fires ? 0 : 2);
      if (rerun) begin
         wr(3'd0, 8'h00);
         get_cnt(held);
         rd(3'd1, s); chk("R11 status after stop", s, 0);
         wait_edges(4);
         get_cnt(v); chk("R11 counter held after stop", v, held);
         wr(3'd0, 8'h43 | 8'(e << 2));
         wait_edges(5);
         get_cnt(v); chk("R11 rearmed waits for new edge", v, held);
         rd(3'd1, s); chk("R11 rearmed status", s, 2);
      end
   endtask

   initial begin
      #1_000_000;
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int v, s;
      reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
      trig_in = 0; ext_tick = 0; rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v); chk("R1 reset register", v, 0);
      end
      chk("R1 reset irq", int'(irq), 0);

      // R12 byte access
      wr(3'd4, 8'hA5); wr(3'd5, 8'h3C); wr(3'd2, 8'h11); wr(3'd3, 8'h22);
      rd(3'd4, v); chk("R12 reload low", v, 8'hA5);
      rd(3'd5, v); chk("R12 reload high", v, 8'h3C);
      get_cnt(v); chk("R12 count readback", v, 16'h2211);

      // R2 R3 prescaler sweep
      for (int c = 0; c < 4; c++) begin
         int d;
         d = (c == 0) ? 1 : (c == 1) ? 8 : (c == 2) ? 64 : 256;
         wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
         wr(3'd0, 8'(c << 4) | 8'h01);
         wait_edges(2*d - 1);
         get_cnt(v); chk($sformatf("R2 R3 first pulse code %0d", c), v, 1);
         wait_edges(d);
         get_cnt(v); chk($sformatf("R3 second pulse code %0d", c), v, 2);
      end

      // R12 write wins over increment
      wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      wr(3'd0, 8'h01);
      wr(3'd2, 8'h50);
      get_cnt(v); chk("R12 write priority", v, 16'h0050);
      wait_edges(2);
      get_cnt(v); chk("R12 count after write", v, 16'h0052);

      // R4 R5 R6 rollover with interrupt enabled
      wr(3'd0, 8'h00);
      wr(3'd4, 8'h34); wr(3'd5, 8'h12); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
      wr(3'd0, 8'h81);
      get_cnt(v); chk("R4 start value", v, 16'hFFFE);
      wait_edges(1);
      get_cnt(v); chk("R4 at max", v, 16'hFFFF);
      chk("R6 irq before rollover", int'(irq), 0);
      wait_edges(1);
      get_cnt(v); chk("R4 reload loaded", v, 16'h1234);
      rd(3'd1, s); chk("R5 flag set", s, 1);
      chk("R6 irq after rollover", int'(irq), 1);
      clear_stat();
      rd(3'd1, s); chk("R5 read clears flag", s, 0);
      chk("R6 irq after clear", int'(irq), 0);
      get_cnt(v); chk("R4 counts on from reload", v, 16'h1235);

      // R5 set wins over same-edge clear, R6 enable low
      wr(3'd0, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
      wr(3'd0, 8'h01);
      reg_addr = 3'd1; reg_rd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_rd = 1'b0;
      rd(3'd1, s); chk("R5 set beats clear", s, 1);
      chk("R6 irq masked", int'(irq), 0);
      clear_stat();

      // R10 external tick source in free mode
      wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      ext_tick = 1'b0;
      wr(3'd0, 8'h41);
      wait_edges(5);
      get_cnt(v); chk("R10 no tick no count", v, 0);
      ext_tick = 1'b1;
      wait_edges(4);
      get_cnt(v); chk("R10 counts ticks", v, 4);
      ext_tick = 1'b0;
      wait_edges(3);
      get_cnt(v); chk("R10 holds without ticks", v, 4);

      // R7 R8 R9 R11 gated mode per edge code
      gated_case(0, 1'b0, 1'b1, "rise", 1'b1);
      gated_case(0, 1'b1, 1'b0, "rise ignores fall", 1'b0);
      gated_case(1, 1'b1, 1'b1, "fall", 1'b0);
      gated_case(1, 1'b0, 1'b0, "fall ignores rise", 1'b0);
      gated_case(2, 1'b1, 1'b1, "either", 1'b0);
      gated_case(3, 1'b0, 1'b0, "none", 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule